// File: doc/BRIEF.md
# Banked Vector Memory Access Scheduler

This block plans the bank accesses of one vector load or store. Element addresses arrive one per cycle. An element whose address is all ones is inactive and is dropped. Every other element goes into the lane queue chosen by the low bits of its address. The queue keeps only the bank index that the element will need. When the element flagged as last has been accepted, the block starts scheduling.

In each scheduling cycle, every lane with a waiting element asks for the bank at the head of its queue. Lanes are visited from index 0 upward, and a lane wins only if its bank is free and no lower lane took that bank in the same cycle. A bank that has been granted stays occupied for a fixed number of further cycles. Its timer is counted down at the start of each scheduling cycle, before that cycle's grants are made.

The block reports every scheduling cycle on a registered grant port. Once every queue is empty and every bank is free, it pulses a done flag together with the job's cycle total: the pipeline depth minus one, plus one for each scheduling cycle before the drained cycle. The issue logic uses that pulse to release the busy marks on the instruction's registers. Only one job is in flight at a time.

Top module: `vec_bank_sched`

## Requirements
- R1: After reset, grant_valid, job_done and sched_busy are 0 and job_cycles is 0.
- R2: An element presented with in_addr equal to all ones (16'hFFFF by default) enqueues nothing. A job made only of such elements finishes with no grant cycles.
- R3: An active element is queued in lane in_addr mod NUM_LANES, taken from the low bits (power of two, default 8). Each lane serves its elements in arrival order, and a lane holds up to LANE_DEPTH (64) elements.
- R4: An element's bank is in_addr mod NUM_BANKS, taken from the low bits (default 4). In a scheduling cycle the lanes are considered from index 0 upward. The lowest lane whose head wants a free bank gets that bank, and at most one lane is granted per bank per cycle. grant_lanes bit l marks lane l, and grant_banks bit b marks bank b.
- R5: A bank granted in one scheduling cycle cannot be granted in the next BUSY_TIME (default 3) scheduling cycles. It can be granted again in the scheduling cycle after those.
- R6: Each scheduling cycle before the drained cycle produces one grant_valid cycle, possibly with empty masks. job_cycles at job_done equals PIPE_DEPTH-1 (default 4) plus the number of those cycles.
- R7: job_done is high for exactly one cycle, in the cycle right after the last grant_valid. There is no gap between consecutive grant_valid cycles of a job.
- R8: While sched_busy is high, in_valid and in_last are ignored. Addresses offered then are never scheduled, and no new job starts.
- R9: A job with no active elements reports job_cycles = PIPE_DEPTH-1. A single element reports PIPE_DEPTH+BUSY_TIME+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element address present |
| in_addr | input | ADDR_W | Element address, all ones means inactive |
| in_last | input | 1 | Marks the job's final element |
| sched_busy | output | 1 | Job being scheduled, input ignored |
| grant_valid | output | 1 | One scheduling cycle reported |
| grant_lanes | output | NUM_LANES | Lanes granted in that cycle |
| grant_banks | output | NUM_BANKS | Banks granted in that cycle |
| job_done | output | 1 | Job drained and all banks free |
| job_cycles | output | CNT_W | Cycle total of the finished job |

## Verification
The element carrying in_last is captured on a rising edge. Scheduling starts in the next cycle, and its first grant record is visible after the following rising edge. After that, one grant record follows on every edge, and job_done follows the last record by exactly one cycle. The bench samples all outputs on falling edges. A reference model, written from the rules above, queues the expected grant masks and cycle totals in order, and the monitor pops one entry per grant_valid or job_done. Any gap, extra record or missing record is therefore flagged in the cycle where it occurs.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic {PH_COLLECT = 1'b0, PH_RUN = 1'b1} phase_t;
endpackage

// File: rtl/vbs_lane_fifo.sv
module vbs_lane_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] fill;

  // storage without reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CNT_W'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/vbs_bank_arbiter.sv
module vbs_bank_arbiter #(
  parameter int NUM_LANES = 8,
  parameter int NUM_BANKS = 4,
  parameter int BUSY_TIME = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 step,
  input  logic [NUM_LANES-1:0]                 req,
  input  logic [NUM_LANES*$clog2(NUM_BANKS)-1:0] req_bank,
  output logic [NUM_LANES-1:0]                 gnt_o,
  output logic [NUM_BANKS-1:0]                 taken_o,
  output logic                                 any_busy_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int TW     = (BUSY_TIME > 0) ? $clog2(BUSY_TIME + 1) : 1;

  logic [NUM_BANKS-1:0] busy_q;
  logic [TW-1:0]        tmr_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] avail;
  logic [BANK_W-1:0]    bank_sel [NUM_LANES];
  logic [NUM_LANES-1:0] gnt;
  logic [NUM_BANKS-1:0] taken;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_sel
    assign bank_sel[l] = req_bank[l*BANK_W +: BANK_W];
  end

  // a bank whose timer reaches zero is freed before this cycle's grants
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_avail
    assign avail[b] = !busy_q[b] || (tmr_q[b] == '0);
  end

  // fixed priority: lower lane index claims first
  always_comb begin
    gnt   = '0;
    taken = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (req[l] && avail[bank_sel[l]] && !taken[bank_sel[l]]) begin
        gnt[l]              = 1'b1;
        taken[bank_sel[l]]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      for (int b = 0; b < NUM_BANKS; b++) tmr_q[b] <= '0;
    end else if (step) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (taken[b]) begin
          busy_q[b] <= 1'b1;
          tmr_q[b]  <= TW'(BUSY_TIME);
        end else if (busy_q[b]) begin
          if (tmr_q[b] == '0) busy_q[b] <= 1'b0;
          else                tmr_q[b]  <= tmr_q[b] - 1'b1;
        end
      end
    end
  end

  assign gnt_o      = gnt;
  assign taken_o    = taken;
  assign any_busy_o = |busy_q;

  if (BUSY_TIME > 0) begin : g_hold_chk
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (|taken) |-> ((taken & $past(taken)) == '0));
  end
endmodule

// File: rtl/vec_bank_sched.sv
module vec_bank_sched #(
  parameter int ADDR_W     = 16,
  parameter int NUM_LANES  = 8,
  parameter int NUM_BANKS  = 4,
  parameter int LANE_DEPTH = 64,
  parameter int BUSY_TIME  = 3,
  parameter int PIPE_DEPTH = 5,
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic                 in_last,
  output logic                 sched_busy,
  output logic                 grant_valid,
  output logic [NUM_LANES-1:0] grant_lanes,
  output logic [NUM_BANKS-1:0] grant_banks,
  output logic                 job_done,
  output logic [CNT_W-1:0]     job_cycles
);
  import vbs_pkg::*;

  localparam int LANE_W = $clog2(NUM_LANES);
  localparam int BANK_W = $clog2(NUM_BANKS);

  phase_t               phase_q;
  logic                 accept;
  logic                 active;
  logic [LANE_W-1:0]    lane_sel;
  logic [NUM_LANES-1:0] push;
  logic [NUM_LANES-1:0] empty;
  logic [NUM_LANES-1:0] full;
  logic [NUM_LANES-1:0] pend;
  logic [NUM_LANES-1:0] req;
  logic [NUM_LANES-1:0] gnt;
  logic [NUM_BANKS-1:0] taken;
  logic [NUM_LANES*BANK_W-1:0] heads;
  logic                 any_busy;
  logic                 running;
  logic                 finish;
  logic                 step;
  logic [CNT_W-1:0]     tally_q;

  assign accept   = in_valid && (phase_q == PH_COLLECT);
  assign active   = accept && (in_addr != '1);
  assign lane_sel = in_addr[LANE_W-1:0];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign push[l] = active && (lane_sel == LANE_W'(l));
    vbs_lane_fifo #(.DEPTH(LANE_DEPTH), .WIDTH(BANK_W)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (push[l]),
      .push_data (in_addr[BANK_W-1:0]),
      .pop       (gnt[l]),
      .head      (heads[l*BANK_W +: BANK_W]),
      .empty     (empty[l]),
      .full      (full[l])
    );
  end

  assign pend    = ~empty;
  assign running = (phase_q == PH_RUN);
  assign finish  = running && !(|pend) && !any_busy;
  assign step    = running && !finish;
  assign req     = step ? pend : '0;

  vbs_bank_arbiter #(
    .NUM_LANES (NUM_LANES),
    .NUM_BANKS (NUM_BANKS),
    .BUSY_TIME (BUSY_TIME)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .req        (req),
    .req_bank   (heads),
    .gnt_o      (gnt),
    .taken_o    (taken),
    .any_busy_o (any_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_COLLECT;
      tally_q     <= '0;
      grant_valid <= 1'b0;
      grant_lanes <= '0;
      grant_banks <= '0;
      job_done    <= 1'b0;
      job_cycles  <= '0;
    end else begin
      grant_valid <= step;
      grant_lanes <= gnt;
      grant_banks <= taken;
      job_done    <= finish;
      if (accept && in_last) begin
        phase_q <= PH_RUN;
        tally_q <= CNT_W'(PIPE_DEPTH - 1);
      end else if (step) begin
        tally_q <= tally_q + 1'b1;
      end else if (finish) begin
        phase_q    <= PH_COLLECT;
        job_cycles <= tally_q;
      end
    end
  end

  assign sched_busy = running;

  // R4
  grant_pair_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> ($countones(grant_lanes) == $countones(grant_banks)));
  // R4
  grant_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt & empty) == '0));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    job_done |=> !job_done);
  // R6
  done_count_chk: assert property (@(posedge clk) disable iff (rst)
    job_done |-> (job_cycles >= CNT_W'(PIPE_DEPTH - 1)));
  // R8
  ignore_run_chk: assert property (@(posedge clk) disable iff (rst)
    running |-> (push == '0));
endmodule

// File: tb/vec_bank_sched_test.sv
module vec_bank_sched_test;
  localparam int AW = 16;
  localparam int NL = 8;
  localparam int NB = 4;
  localparam int LD = 64;
  localparam int BT = 3;
  localparam int PD = 5;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic in_last = 1'b0;
  logic sched_busy, grant_valid, job_done;
  logic [NL-1:0] grant_lanes;
  logic [NB-1:0] grant_banks;
  logic [CW-1:0] job_cycles;

  always #5 clk = ~clk;

  vec_bank_sched #(.ADDR_W(AW), .NUM_LANES(NL), .NUM_BANKS(NB), .LANE_DEPTH(LD),
                   .BUSY_TIME(BT), .PIPE_DEPTH(PD), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_last(in_last),
    .sched_busy(sched_busy), .grant_valid(grant_valid), .grant_lanes(grant_lanes),
    .grant_banks(grant_banks), .job_done(job_done), .job_cycles(job_cycles));

  int tests = 0;
  int fails = 0;
  int jobs_seen = 0;
  int last_cycles = 0;
  bit prev_gv = 1'b0;
  logic [NL+NB-1:0] exp_gnt [$];
  int exp_cyc [$];
  int addrs [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input int n);
    int q [NL][$];
    bit bb [NB];
    int bc [NB];
    int cnt;
    for (int b = 0; b < NB; b++) begin bb[b] = 0; bc[b] = 0; end
    for (int i = 0; i < n; i++)
      if (addrs[i] != 16'hFFFF) q[addrs[i] % NL].push_back(addrs[i] % NB);
    cnt = PD - 1;
    forever begin
      bit lanes_free, banks_free;
      logic [NL-1:0] lm;
      logic [NB-1:0] bm;
      lanes_free = 1; banks_free = 1; lm = '0; bm = '0;
      for (int l = 0; l < NL; l++) if (q[l].size() > 0) lanes_free = 0;
      for (int b = 0; b < NB; b++)
        if (bb[b]) begin
          banks_free = 0;
          if (bc[b] == 0) bb[b] = 0; else bc[b]--;
        end
      if (lanes_free && banks_free) break;
      for (int l = 0; l < NL; l++)
        if (q[l].size() > 0 && !bb[q[l][0]]) begin
          int b;
          b = q[l][0];
          void'(q[l].pop_front());
          bb[b] = 1; bc[b] = BT;
          lm[l] = 1'b1; bm[b] = 1'b1;
        end
      exp_gnt.push_back({lm, bm});
      cnt++;
    end
    exp_cyc.push_back(cnt);
  endtask

  // monitor: pops expectations as the design reports
  always @(negedge clk) begin
    if (!rst) begin
      if (grant_valid) begin
        if (exp_gnt.size() == 0) check(0, "R8 unexpected grant", {grant_lanes, grant_banks}, 0);
        else begin
          logic [NL+NB-1:0] e;
          e = exp_gnt.pop_front();
          check({grant_lanes, grant_banks} == e, "R4/R5 grant masks", {grant_lanes, grant_banks}, e);
        end
      end
      if (job_done) begin
        jobs_seen++;
        last_cycles = job_cycles;
        check(exp_gnt.size() == 0, "R6 grant records left at done", exp_gnt.size(), 0);
        if (exp_cyc.size() == 0) check(0, "R8 unexpected done", job_cycles, 0);
        else begin
          int e;
          e = exp_cyc.pop_front();
          check(job_cycles == CW'(e), "R6 job_cycles", job_cycles, e);
        end
        check(!grant_valid, "R7 done with grant", grant_valid, 0);
      end
      if (prev_gv && !grant_valid && !job_done) check(0, "R7 gap after grant", 0, 1);
      prev_gv = grant_valid;
    end
  end

  task automatic run_job(input int n, input bit junk);
    int target;
    model(n);
    target = jobs_seen + 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_addr = AW'(addrs[i]); in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (junk) begin
      // R8: offered while busy, must be ignored
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        in_valid = 1'b1; in_addr = AW'(k * 4); in_last = (k == 2);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
    end
    while (jobs_seen < target) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!grant_valid && !job_done && !sched_busy && job_cycles == '0, "R1 reset state",
          {grant_valid, job_done, sched_busy}, 0);

    // R9 single element
    addrs[0] = 5;
    run_job(1, 0);
    check(last_cycles == PD + BT + 1, "R9 single element total", last_cycles, PD + BT + 1);

    // R2 only inactive elements
    addrs[0] = 16'hFFFF; addrs[1] = 16'hFFFF; addrs[2] = 16'hFFFF;
    run_job(3, 0);
    check(last_cycles == PD - 1, "R2 empty job total", last_cycles, PD - 1);

    // R4 lanes 0 and 4 both want bank 0, lane 0 first
    addrs[0] = 4; addrs[1] = 0;
    run_job(2, 0);
    check(last_cycles == 13, "R4 conflict total", last_cycles, 13);

    // R3 sequential addresses, mixed lanes and banks, with inactive holes
    for (int i = 0; i < 20; i++) addrs[i] = (i % 7 == 3) ? 16'hFFFF : i;
    run_job(20, 0);

    // R5 stride hitting one bank from several lanes
    for (int i = 0; i < 16; i++) addrs[i] = i * 4;
    run_job(16, 0);

    // R3 full lane depth in lane 0
    for (int i = 0; i < 64; i++) addrs[i] = i * 8;
    run_job(64, 0);

    // R8 input during a running job
    for (int i = 0; i < 6; i++) addrs[i] = i * 3 + 1;
    run_job(6, 1);
    repeat (20) @(negedge clk);
    check(!sched_busy && !grant_valid, "R8 no job started by ignored input", sched_busy, 0);
    addrs[0] = 2;
    run_job(1, 0);
    check(last_cycles == PD + BT + 1, "R8 next job unaffected", last_cycles, PD + BT + 1);

    // R6 pseudo-random jobs
    seed = 32'h1234_5677;
    for (int j = 0; j < 6; j++) begin
      int n;
      n = 8 + j * 9;
      for (int i = 0; i < n; i++) begin
        seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
        addrs[i] = ((seed & 7) == 0) ? 16'hFFFF : ((seed >>> 4) & 255);
      end
      run_job(n, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule